// File: doc/BRIEF.md
# AHB slave bridge to a custom core

This block lets a simple custom core hang on an AHB bus as a slave without knowing the bus protocol. It watches the address phase of every transfer that selects it. It then turns that transfer into fixed-timing sideband signals for the core: write and read strobes, an active-low enable, a 16-bit local address, two address-decoded region flags, flags marking where a write burst begins and ends, and two write-data ports that load from the bus by address. It returns a single status word to the bus.

Each core-side signal has a fixed polarity and a fixed cycle offset relative to the accepted address phase, which is the reference cycle. Offset 0 means the signal is combinational in the reference cycle. Offset 1 means it is registered and appears in the following cycle, which is the data phase. The bridge never stalls the bus: every transfer completes with an OKAY response and no wait states. Address windows are compared on the upper 16 address bits. The window values are parameters.

Top module: `ahb_core_bridge`

## Requirements
- R1: A transfer is accepted only in a cycle where hsel=1, hready=1 and htrans is NONSEQ (2'b10) or SEQ (2'b11). In the cycle after an accepted write, core_wr_vld is 1. In the cycle after an accepted read, core_rd_vld is 1. Both strobes are 0 otherwise and are never 1 together.
- R2: core_cs_n is 0 in exactly the cycle after an accepted transfer and is 1 otherwise.
- R3: core_addr takes haddr[15:0] of each accepted transfer one cycle later and holds its value between transfers.
- R4: dec_hi is 1 in the same cycle as an accepted transfer whose address has upper half 16'h8000, and is 0 otherwise.
- R5: dec_lo_n is 0 in the cycle after an accepted transfer whose address has upper half 16'h8100, and is 1 otherwise.
- R6: wport_a (32 bits) loads hwdata at the end of the data phase of a write to upper half 16'h6000. The new value is visible from the next cycle, and wport_a keeps its value otherwise.
- R7: wport_b (16 bits) loads hwdata[15:0] at the end of the data phase of a write to upper half 16'h6001, and keeps its value otherwise.
- R8: During the data phase of a read to upper half 16'h6100, hrdata equals status_in. In every other cycle, including reads of other addresses, hrdata is 0.
- R9: burst_first is 1, combinationally in the same cycle, for an accepted NONSEQ write, and is 0 otherwise.
- R10: For a write with hburst SINGLE (3'b000) or INCR (3'b001), burst_last is 1 during its data phase when the concurrent address phase is not SEQ or BUSY with hsel=1. A BUSY cycle continues the burst.
- R11: For fixed-length write bursts (hburst 3'b010/3'b011 = 4 beats, 3'b100/3'b101 = 8, 3'b110/3'b111 = 16), burst_last is 1 only during the data phase of the final beat by count. A burst cut short gets no end flag.
- R12: IDLE and BUSY cycles, cycles with hsel=0 and cycles with hready=0 produce no strobe, no enable, no region flag and no port load.
- R13: hreadyout is always 1 and hresp is always OKAY (2'b00).
- R14: During reset: core_cs_n=1, dec_lo_n=1, core_wr_vld=0, core_rd_vld=0, burst_last=0, core_addr=0, wport_a=0 and wport_b=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Bus address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write |
| hburst | input | 3 | Burst type |
| hwdata | input | 32 | Write data (data phase) |
| hready | input | 1 | Bus-wide ready |
| hreadyout | output | 1 | This slave's ready, always 1 |
| hresp | output | 2 | Response, always OKAY |
| hrdata | output | 32 | Read data |
| status_in | input | 32 | Status word from the core |
| core_wr_vld | output | 1 | Write strobe to core |
| core_rd_vld | output | 1 | Read strobe to core |
| core_cs_n | output | 1 | Active-low core enable |
| core_addr | output | 16 | Local core address |
| dec_hi | output | 1 | Region flag, active high, offset 0 |
| dec_lo_n | output | 1 | Region flag, active low, offset 1 |
| burst_first | output | 1 | First write beat of a burst |
| burst_last | output | 1 | Last write beat of a burst |
| wport_a | output | 32 | Write-data port A |
| wport_b | output | 16 | Write-data port B |

## Verification
Most of the state is a one-cycle record of the accepted address phase, so a fault in it shows at the core-side pins in the very next cycle. It appears as a strobe or enable that is missing or in the wrong place, or as a region flag with the wrong polarity. A corrupted direction or region bit also shows in that cycle as a wrong hrdata or a port that loads when it should not. The burst beat counter is the only state that lives longer: a fault there stays hidden until the final beat of a fixed-length burst, where the end flag is missing, early or late. The bench therefore includes a burst with a BUSY cycle in the middle and a truncated burst.

// File: rtl/ahb_core_bridge.sv
module ahb_core_bridge #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CAW = 16,
  parameter int BW  = 16,
  parameter logic [AW-1:0] WIN_MASK  = 32'hFFFF_0000,
  parameter logic [AW-1:0] HI_WIN    = 32'h8000_0000,
  parameter logic [AW-1:0] LO_WIN    = 32'h8100_0000,
  parameter logic [AW-1:0] PA_WIN    = 32'h6000_0000,
  parameter logic [AW-1:0] PB_WIN    = 32'h6001_0000,
  parameter logic [AW-1:0] ST_WIN    = 32'h6100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [2:0]    hburst,
  input  logic [DW-1:0] hwdata,
  input  logic          hready,
  output logic          hreadyout,
  output logic [1:0]    hresp,
  output logic [DW-1:0] hrdata,
  input  logic [DW-1:0] status_in,
  output logic          core_wr_vld,
  output logic          core_rd_vld,
  output logic          core_cs_n,
  output logic [CAW-1:0] core_addr,
  output logic          dec_hi,
  output logic          dec_lo_n,
  output logic          burst_first,
  output logic          burst_last,
  output logic [DW-1:0] wport_a,
  output logic [BW-1:0] wport_b
);

  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam int         CW      = 4;

  logic accept, is_nseq, cont;
  logic in_hi, in_lo, in_a, in_b, in_st;

  assign accept  = hsel & hready & htrans[1];
  assign is_nseq = (htrans == TR_NSEQ);
  assign cont    = hsel & htrans[0];

  assign in_hi = (haddr & WIN_MASK) == HI_WIN;
  assign in_lo = (haddr & WIN_MASK) == LO_WIN;
  assign in_a  = (haddr & WIN_MASK) == PA_WIN;
  assign in_b  = (haddr & WIN_MASK) == PB_WIN;
  assign in_st = (haddr & WIN_MASK) == ST_WIN;

  // beat position inside fixed-length bursts
  logic [CW-1:0] beat_q, beat_idx, final_idx;
  logic          fixed_len;

  always_comb begin
    fixed_len = 1'b1;
    case (hburst)
      3'b010, 3'b011: final_idx = CW'(3);
      3'b100, 3'b101: final_idx = CW'(7);
      3'b110, 3'b111: final_idx = CW'(15);
      default: begin
        final_idx = '0;
        fixed_len = 1'b0;
      end
    endcase
  end

  assign beat_idx = is_nseq ? '0 : beat_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      beat_q <= '0;
    else if (accept) beat_q <= beat_idx + CW'(1);

  // data-phase record
  logic dp_vld, dp_wr, dp_a, dp_b, dp_st, dp_fixed, dp_flast;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dp_vld   <= 1'b0;
      dp_wr    <= 1'b0;
      dp_a     <= 1'b0;
      dp_b     <= 1'b0;
      dp_st    <= 1'b0;
      dp_fixed <= 1'b0;
      dp_flast <= 1'b0;
    end else begin
      dp_vld <= accept;
      if (accept) begin
        dp_wr    <= hwrite;
        dp_a     <= in_a;
        dp_b     <= in_b;
        dp_st    <= in_st;
        dp_fixed <= fixed_len;
        dp_flast <= fixed_len & (beat_idx == final_idx);
      end
    end

  // offset-1 sideband
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      core_wr_vld <= 1'b0;
      core_rd_vld <= 1'b0;
      core_cs_n   <= 1'b1;
      dec_lo_n    <= 1'b1;
      core_addr   <= '0;
    end else begin
      core_wr_vld <= accept & hwrite;
      core_rd_vld <= accept & ~hwrite;
      core_cs_n   <= ~accept;
      dec_lo_n    <= ~(accept & in_lo);
      if (accept) core_addr <= haddr[CAW-1:0];
    end

  // write-data ports
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wport_a <= '0;
      wport_b <= '0;
    end else if (dp_vld & dp_wr) begin
      if (dp_a) wport_a <= hwdata;
      if (dp_b) wport_b <= hwdata[BW-1:0];
    end

  // offset-0 sideband and bus response
  assign dec_hi      = accept & in_hi;
  assign burst_first = accept & hwrite & is_nseq;
  assign burst_last  = dp_vld & dp_wr & (dp_fixed ? dp_flast : ~cont);
  assign hrdata      = (dp_vld & ~dp_wr & dp_st) ? status_in : '0;
  assign hreadyout   = 1'b1;
  assign hresp       = 2'b00;

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_wr_vld && core_rd_vld));
  p_wr_after_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_vld |-> $past(hsel && hready && htrans[1] && hwrite));
  p_cs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_cs_n) == (core_wr_vld || core_rd_vld));
  p_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !core_cs_n |-> core_addr == $past(haddr[CAW-1:0]));
  p_lo_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_lo_n |-> $past(hsel && hready && htrans[1] && ((haddr & WIN_MASK) == LO_WIN)));
  p_porta_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_vld && dp_wr && dp_a) |=> $stable(wport_a));
  p_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hrdata != '0) |-> core_rd_vld);
  p_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_first |-> (hsel && hwrite && htrans == TR_NSEQ));
  p_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |-> core_wr_vld);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsel && hready && htrans[1]) |=> core_cs_n);

endmodule

// File: tb/sim_ahb_core_bridge.sv
module sim_ahb_core_bridge;
  localparam time CLK_T = 10ns;
  localparam logic [31:0] ST0 = 32'hCAFE_0123;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hsel = 0, hwrite = 0, hready = 1;
  logic [31:0] haddr = '0, hwdata = '0, status_in = ST0;
  logic [1:0]  htrans = '0;
  logic [2:0]  hburst = '0;
  logic hreadyout, core_wr_vld, core_rd_vld, core_cs_n, dec_hi, dec_lo_n, burst_first, burst_last;
  logic [1:0]  hresp;
  logic [31:0] hrdata, wport_a;
  logic [15:0] core_addr, wport_b;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  ahb_core_bridge u0 (
    .clk, .rst_n, .hsel, .haddr, .htrans, .hwrite, .hburst, .hwdata, .hready,
    .hreadyout, .hresp, .hrdata, .status_in, .core_wr_vld, .core_rd_vld,
    .core_cs_n, .core_addr, .dec_hi, .dec_lo_n, .burst_first, .burst_last,
    .wport_a, .wport_b);

  typedef struct packed {
    logic sel; logic [1:0] tr; logic wr; logic [2:0] bu; logic rdy;
    logic [31:0] ad; logic [31:0] wd;
    logic cs_n; logic wv; logic rv; logic dhi; logic dlon; logic fst; logic lst;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b0,2'd0,1'b0,3'd0,1'b1,32'h0,         32'h0,         1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b1,2'd2,1'b1,3'd1,1'b1,32'h6000_0010, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h0},
    '{1'b1,2'd3,1'b1,3'd1,1'b1,32'h6000_0014, 32'h1111_1111, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b1,2'd0,1'b0,3'd0,1'b1,32'h0,         32'h2222_2222, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,32'h0},
    '{1'b1,2'd2,1'b0,3'd0,1'b1,32'h6100_0000, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b0,2'd0,1'b0,3'd0,1'b1,32'h0,         32'h0,         1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,ST0},
    '{1'b1,2'd2,1'b1,3'd0,1'b1,32'h8000_1234, 32'h0,         1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,32'h0},
    '{1'b1,2'd2,1'b0,3'd0,1'b1,32'h8100_0004, 32'h3333_3333, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,32'h0},
    '{1'b0,2'd0,1'b0,3'd0,1'b1,32'h0,         32'h0,         1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0},
    '{1'b1,2'd2,1'b1,3'd0,1'b0,32'h8000_0000, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b1,2'd1,1'b1,3'd0,1'b1,32'h8100_0000, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b1,2'd2,1'b1,3'd3,1'b1,32'h6001_0000, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,32'h0},
    '{1'b1,2'd3,1'b1,3'd3,1'b1,32'h6001_0004, 32'hAAAA_0001, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b1,2'd1,1'b1,3'd3,1'b1,32'h6001_0008, 32'hAAAA_0002, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b1,2'd3,1'b1,3'd3,1'b1,32'h6001_0008, 32'h0,         1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b1,2'd3,1'b1,3'd3,1'b1,32'h6001_000C, 32'hAAAA_0003, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b1,2'd2,1'b1,3'd3,1'b1,32'h6000_0000, 32'hAAAA_0004, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,32'h0},
    '{1'b1,2'd3,1'b1,3'd3,1'b1,32'h6000_0004, 32'h5555_0000, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b0,2'd0,1'b0,3'd0,1'b1,32'h0,         32'h6666_0000, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0},
    '{1'b0,2'd0,1'b0,3'd0,1'b1,32'h0,         32'h0,         1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus(input logic s, input logic [1:0] t, input logic w, input logic [2:0] b,
                     input logic r, input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    hsel = s; htrans = t; hwrite = w; hburst = b; hready = r; haddr = a; hwdata = d;
  endtask

  initial begin
    #(CLK_T * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R14 cs_n", 32'(core_cs_n), 32'd1);
    chk("R14 dec_lo_n", 32'(dec_lo_n), 32'd1);
    chk("R14 strobes", {30'd0, core_wr_vld, core_rd_vld}, 32'd0);
    chk("R14 burst_last", 32'(burst_last), 32'd0);
    chk("R14 core_addr", 32'(core_addr), 32'd0);
    chk("R14 wport_a", wport_a, 32'd0);
    chk("R14 wport_b", 32'(wport_b), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(TBL[i].sel, TBL[i].tr, TBL[i].wr, TBL[i].bu, TBL[i].rdy, TBL[i].ad, TBL[i].wd);
      @(negedge clk);
      chk($sformatf("R2 cs_n row %0d", i), 32'(core_cs_n), 32'(TBL[i].cs_n));
      chk($sformatf("R1 wr_vld row %0d", i), 32'(core_wr_vld), 32'(TBL[i].wv));
      chk($sformatf("R1 rd_vld row %0d", i), 32'(core_rd_vld), 32'(TBL[i].rv));
      chk($sformatf("R4 dec_hi row %0d", i), 32'(dec_hi), 32'(TBL[i].dhi));
      chk($sformatf("R5 dec_lo_n row %0d", i), 32'(dec_lo_n), 32'(TBL[i].dlon));
      chk($sformatf("R9 first row %0d", i), 32'(burst_first), 32'(TBL[i].fst));
      chk($sformatf("R10/R11 last row %0d", i), 32'(burst_last), 32'(TBL[i].lst));
      chk($sformatf("R8 hrdata row %0d", i), hrdata, TBL[i].rd);
      chk($sformatf("R13 resp row %0d", i), {29'd0, hreadyout, hresp}, 32'd4);
    end
    chk("R6 wport_a", wport_a, 32'h6666_0000);
    chk("R7 wport_b", 32'(wport_b), 32'h0000_0004);
    chk("R3 core_addr hold", 32'(core_addr), 32'h0000_0004);

    // R12: unselected write must not touch port A nor enable the core
    bus(1'b0, 2'd2, 1'b1, 3'd0, 1'b1, 32'h6000_0000, 32'h0);
    bus(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 32'h0, 32'h9999_9999);
    @(negedge clk);
    chk("R12 cs_n unselected", 32'(core_cs_n), 32'd1);
    bus(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 32'h0, 32'h0);
    @(negedge clk);
    chk("R12 wport_a untouched", wport_a, 32'h6666_0000);

    // R8/R3: new status word and a local address
    status_in = 32'h1234_5678;
    bus(1'b1, 2'd2, 1'b0, 3'd0, 1'b1, 32'h6100_0040, 32'h0);
    bus(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 32'h0, 32'h0);
    @(negedge clk);
    chk("R8 status read", hrdata, 32'h1234_5678);
    chk("R3 core_addr", 32'(core_addr), 32'h0000_0040);

    // R8: unmapped read returns zero
    bus(1'b1, 2'd2, 1'b0, 3'd0, 1'b1, 32'h7000_0000, 32'h0);
    bus(1'b0, 2'd0, 1'b0, 3'd0, 1'b1, 32'h0, 32'h0);
    @(negedge clk);
    chk("R8 unmapped read", hrdata, 32'h0);
    chk("R1 rd_vld unmapped", 32'(core_rd_vld), 32'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule